// File: doc/BRIEF.md
# Address Breakpoint Unit with Forced and Tagged Modes

This block provides one hardware breakpoint for a small CPU core. It watches the CPU address bus, compares each cycle's address against a 16-bit match address, and raises a halt request that sends the core into its halted debug state. A single select input chooses between two styles of breakpoint. In forced style, any bus access to the match address (read, write or opcode fetch) arms a sticky request, and the halt is requested at the first instruction boundary after that access. In tagged style, only an opcode fetched from the match address counts. The block marks that opcode with a tag bit in the same cycle as the fetch, and the CPU carries the tag bit through its instruction queue. The halt is requested only when the tagged opcode reaches the queue head, and that opcode is then not executed.

Forced style works at any address. Tagged style is useful only at addresses that hold opcodes. The block keeps a saturating count of tagged opcodes still in flight. A queue flush clears that count, so a tag left over from discarded instructions cannot cause a halt. A master enable, which is 0 after reset, blocks every request and clears all pending state while it is low.

Top module: `addr_brkpt_unit`

## Requirements
- R1: After reset, `halt_o` and `tag_o` are 0, and no forced or tagged request is pending.
- R2: While `en_i` is 0, `tag_o` stays 0 and `halt_o` is 0 in the following cycle, whatever the other inputs do. Any pending forced request and any tag count are cleared.
- R3: With `en_i`=1 and `force_sel_i`=1, a cycle with `acc_i` or `fetch_i` high and `addr_i` equal to `match_addr_i` in all 16 bits arms a request. An address that differs in any bit arms nothing.
- R4: An armed forced request makes `halt_o` high for exactly one cycle: the cycle after the first `insn_bnd_i` strobe that follows the access. The request is then cleared, so a later boundary gives no halt.
- R5: A boundary strobe in the same cycle as the matching access does not consume that access. The halt comes after the next boundary.
- R6: With `en_i`=1 and `force_sel_i`=0, `tag_o` is high in the same cycle as an opcode fetch (`fetch_i`) from the match address. An `acc_i`-only access or a fetch from another address gives `tag_o`=0 and adds no pending tag.
- R7: In tagged style, when `qhead_i` and `head_tag_i` are both high and at least one tag is pending, `halt_o` is high in the next cycle and the pending count drops by one.
- R8: `flush_i` discards all pending tags. A later tagged queue head does not halt.
- R9: A tagged queue head that arrives with no pending tags gives no halt.
- R10: The pending tag count saturates at QDEPTH. After QDEPTH+1 tagged fetches, QDEPTH+1 tagged heads give exactly QDEPTH halts.
- R11: With `force_sel_i`=1, a fetch from the match address gives `tag_o`=0 and behaves as a forced access.
- R12: Dropping `en_i` for one cycle discards an armed forced request. A boundary after re-enabling gives no halt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Breakpoint enable |
| force_sel_i | input | 1 | 1 selects forced style, 0 selects tagged style |
| match_addr_i | input | ADDR_W | Breakpoint match address |
| addr_i | input | ADDR_W | CPU address bus |
| acc_i | input | 1 | Bus access strobe (read or write) |
| fetch_i | input | 1 | Opcode fetch strobe |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| qhead_i | input | 1 | An opcode reaches the head of the instruction queue |
| head_tag_i | input | 1 | Tag bit carried with the head opcode |
| flush_i | input | 1 | Instruction queue flush |
| tag_o | output | 1 | Tag bit for the opcode fetched this cycle |
| halt_o | output | 1 | Halt request pulse |

## Verification
The bench builds the block with ADDR_W=16 and QDEPTH=2. The small depth lets a short burst of three tagged fetches reach the saturation limit of the pending count and go past it. The full 16-bit width means a near-miss address, one bit away from the match address, is checked against the real comparator.

// File: rtl/abk_pkg.sv
package abk_pkg;

  // next value of a saturating in-flight counter with push and pop
  function automatic int unsigned tag_count_next(input int unsigned cur,
                                                 input logic push,
                                                 input logic pop,
                                                 input int unsigned cap);
    int unsigned nxt;
    nxt = cur;
    if (pop && nxt != 0) nxt = nxt - 1;
    if (push && nxt < cap) nxt = nxt + 1;
    return nxt;
  endfunction

  // full-width address equality
  function automatic logic addr_equal(input logic [63:0] a, input logic [63:0] b);
    return a == b;
  endfunction

endpackage

// File: rtl/abk_cmp.sv
module abk_cmp #(
  parameter int ADDR_W = 16
) (
  input  logic              en_i,
  input  logic              force_sel_i,
  input  logic [ADDR_W-1:0] match_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              acc_i,
  input  logic              fetch_i,
  output logic              force_hit_o,
  output logic              tag_hit_o
);
  import abk_pkg::*;

  logic addr_eq;

  always_comb begin
    addr_eq     = addr_equal(64'(addr_i), 64'(match_addr_i));
    force_hit_o = en_i && force_sel_i && (acc_i || fetch_i) && addr_eq;
    tag_hit_o   = en_i && !force_sel_i && fetch_i && addr_eq;
  end
endmodule

// File: rtl/abk_force.sv
module abk_force (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bnd_i,
  input  logic hit_i,
  output logic pend_o,
  output logic fire_o
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (!en_i)   pend_q <= 1'b0;
    else if (bnd_i)   pend_q <= hit_i;
    else if (hit_i)   pend_q <= 1'b1;
  end

  assign pend_o = pend_q;
  assign fire_o = en_i && bnd_i && pend_q;
endmodule

// File: rtl/abk_tagtrk.sv
module abk_tagtrk #(
  parameter int QDEPTH = 4,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             push_i,
  input  logic             pop_req_i,
  input  logic             flush_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             fire_o
);
  import abk_pkg::*;

  logic [CNT_W-1:0] cnt_q;
  logic             pop;

  assign pop    = en_i && pop_req_i && (cnt_q != '0);
  assign fire_o = pop;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (!en_i || flush_i)  cnt_q <= '0;
    else cnt_q <= CNT_W'(tag_count_next(32'(cnt_q), push_i, pop, 32'(QDEPTH)));
  end
endmodule

// File: rtl/addr_brkpt_unit.sv
module addr_brkpt_unit #(
  parameter int ADDR_W = 16,
  parameter int QDEPTH = 4,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              force_sel_i,
  input  logic [ADDR_W-1:0] match_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              acc_i,
  input  logic              fetch_i,
  input  logic              insn_bnd_i,
  input  logic              qhead_i,
  input  logic              head_tag_i,
  input  logic              flush_i,
  output logic              tag_o,
  output logic              halt_o
);
  // internal events, named for the checker
  logic             force_hit;
  logic             tag_hit;
  logic             force_pend;
  logic             force_fire;
  logic             tag_fire;
  logic [CNT_W-1:0] tag_cnt;
  logic             halt_q;

  abk_cmp #(.ADDR_W(ADDR_W)) u_cmp (
    .en_i         (en_i),
    .force_sel_i  (force_sel_i),
    .match_addr_i (match_addr_i),
    .addr_i       (addr_i),
    .acc_i        (acc_i),
    .fetch_i      (fetch_i),
    .force_hit_o  (force_hit),
    .tag_hit_o    (tag_hit)
  );

  abk_force u_force (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .bnd_i  (insn_bnd_i),
    .hit_i  (force_hit),
    .pend_o (force_pend),
    .fire_o (force_fire)
  );

  abk_tagtrk #(.QDEPTH(QDEPTH)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .push_i    (tag_hit),
    .pop_req_i (qhead_i && head_tag_i),
    .flush_i   (flush_i),
    .cnt_o     (tag_cnt),
    .fire_o    (tag_fire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= force_fire || tag_fire;
  end

  assign tag_o  = tag_hit;
  assign halt_o = halt_q;
endmodule

// File: rtl/abk_chk.sv
module abk_chk #(
  parameter int QDEPTH = 4,
  localparam int CNT_W = $clog2(QDEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_i,
  input logic             insn_bnd_i,
  input logic             qhead_i,
  input logic             head_tag_i,
  input logic             flush_i,
  input logic             tag_o,
  input logic             halt_o,
  input logic             force_pend,
  input logic [CNT_W-1:0] tag_cnt
);

  p_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!halt_o && tag_cnt == '0 && !force_pend));

  p_forced_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && insn_bnd_i && force_pend) |=> halt_o);

  p_halt_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> $past(insn_bnd_i || (qhead_i && head_tag_i)));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> tag_cnt == '0);

  p_stale_head_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (qhead_i && head_tag_i && tag_cnt == '0 && !(insn_bnd_i && force_pend)) |=> !halt_o);

  p_cnt_cap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tag_cnt <= CNT_W'(QDEPTH));

  p_tag_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tag_o && !flush_i && !(qhead_i && head_tag_i) && tag_cnt < CNT_W'(QDEPTH))
      |=> tag_cnt == $past(tag_cnt) + 1'b1);

endmodule

bind addr_brkpt_unit abk_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .insn_bnd_i (insn_bnd_i),
  .qhead_i    (qhead_i),
  .head_tag_i (head_tag_i),
  .flush_i    (flush_i),
  .tag_o      (tag_o),
  .halt_o     (halt_o),
  .force_pend (force_pend),
  .tag_cnt    (tag_cnt)
);

// File: tb/addr_brkpt_unit_tb.sv
`timescale 1ns/1ps
module addr_brkpt_unit_tb;
  localparam int AW = 16;
  localparam int QD = 2;
  localparam logic [AW-1:0] MATCH = 16'hA5C3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, fsel = 1'b0, acc = 1'b0, fetch = 1'b0;
  logic          bnd = 1'b0, qhead = 1'b0, htag = 1'b0, flush = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          tag_o, halt_o;
  int            n_chk = 0, n_bad = 0;
  bit            done = 1'b0;

  always #2.5 clk = ~clk;

  addr_brkpt_unit #(.ADDR_W(AW), .QDEPTH(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .force_sel_i(fsel),
    .match_addr_i(MATCH), .addr_i(addr), .acc_i(acc), .fetch_i(fetch),
    .insn_bnd_i(bnd), .qhead_i(qhead), .head_tag_i(htag), .flush_i(flush),
    .tag_o(tag_o), .halt_o(halt_o)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    acc = 0; fetch = 0; bnd = 0; qhead = 0; htag = 0; flush = 0; addr = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk(halt_o, 1'b0, "R1 halt after reset");
    chk(tag_o, 1'b0, "R1 tag after reset");
    en = 1; bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R1 no pending forced request");
    qhead = 1; htag = 1; tick(); idle();
    chk(halt_o, 1'b0, "R1 no pending tag");
  endtask

  task automatic t_forced();
    en = 1; fsel = 1;
    addr = MATCH; acc = 1; tick(); idle();
    chk(halt_o, 1'b0, "R3 no halt before boundary");
    tick();
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b1, "R4 halt after boundary");
    tick();
    chk(halt_o, 1'b0, "R4 single pulse");
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R4 request cleared");
    addr = MATCH ^ 16'h0001; acc = 1; tick(); idle();
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R3 near-miss address");
    addr = MATCH ^ 16'h8000; acc = 1; tick(); idle();
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R3 near-miss top bit");
  endtask

  task automatic t_same_cycle();
    addr = MATCH; acc = 1; bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R5 same-cycle boundary not consumed");
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b1, "R5 halt at next boundary");
    tick();
  endtask

  task automatic t_force_fetch();
    fsel = 1; addr = MATCH; fetch = 1; #1;
    chk(tag_o, 1'b0, "R11 no tag in forced style");
    tick(); idle();
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b1, "R11 fetch acts as forced access");
    tick();
  endtask

  task automatic t_disabled();
    en = 0; fsel = 1; addr = MATCH; acc = 1; tick(); idle();
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R2 forced blocked when disabled");
    fsel = 0; addr = MATCH; fetch = 1; #1;
    chk(tag_o, 1'b0, "R2 no tag when disabled");
    tick(); idle();
    en = 1; qhead = 1; htag = 1; tick(); idle();
    chk(halt_o, 1'b0, "R2 no tag counted when disabled");
  endtask

  task automatic t_en_drop();
    en = 1; fsel = 1; addr = MATCH; acc = 1; tick(); idle();
    en = 0; tick();
    en = 1; bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R12 enable drop discards request");
  endtask

  task automatic t_tagged();
    en = 1; fsel = 0;
    addr = MATCH; fetch = 1; #1;
    chk(tag_o, 1'b1, "R6 tag on matching fetch");
    tick(); idle();
    addr = MATCH; acc = 1; #1;
    chk(tag_o, 1'b0, "R6 no tag on data access");
    tick(); idle();
    addr = MATCH ^ 16'h0100; fetch = 1; #1;
    chk(tag_o, 1'b0, "R6 no tag on other address");
    tick(); idle();
    bnd = 1; tick(); idle();
    chk(halt_o, 1'b0, "R6 boundary ignored in tagged style");
    qhead = 1; htag = 1; tick(); idle();
    chk(halt_o, 1'b1, "R7 halt at tagged head");
    tick();
    qhead = 1; htag = 1; tick(); idle();
    chk(halt_o, 1'b0, "R9 stale head tag");
  endtask

  task automatic t_flush();
    addr = MATCH; fetch = 1; tick(); idle();
    flush = 1; tick(); idle();
    qhead = 1; htag = 1; tick(); idle();
    chk(halt_o, 1'b0, "R8 flush discards tags");
  endtask

  task automatic t_saturate();
    int halts = 0;
    for (int i = 0; i < QD + 1; i++) begin
      addr = MATCH; fetch = 1; tick(); idle();
    end
    for (int i = 0; i < QD + 1; i++) begin
      qhead = 1; htag = 1; tick(); idle();
      if (halt_o) halts++;
    end
    n_chk++;
    if (halts != QD) begin
      n_bad++;
      $display("FAIL R10: got %0d halts expected %0d", halts, QD);
    end
  endtask

  initial begin
    #1;
    repeat (3) tick();
    rst_n = 1; tick();
    t_reset();
    t_forced();
    t_same_cycle();
    t_force_fetch();
    t_disabled();
    t_en_drop();
    t_tagged();
    t_flush();
    t_saturate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule